// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI-style master from the module clock. Software picks one of two division schemes with a single mode bit. The linear scheme divides by an even count, 2*(N+1), using an 8-bit field. The exponent scheme divides by a power of two, 2^M, using a 4-bit field. While the run enable is low the block holds its counter cleared and parks the serial clock at the idle level chosen by the polarity input.

While running, the block toggles the serial clock whenever a half period ends and raises `toggleEn` in that same cycle. It also tells the two kinds of edge apart. `leadTick` marks the edge that leaves the idle level, and `trailTick` marks the edge that returns to it, so a shift engine can sample on one and launch on the other. A divisor written during a transfer is latched only at a full-period boundary, which is the trailing edge, so no period is ever cut short. The module clock must be at least twice the serial clock rate, and the clamp of M=0 to divide-by-2 enforces that limit.

Top module: `sclk_divider`

## Requirements
- R1: With `linMode`=1 the serial clock level changes once every `linDiv`+1 module clocks while running, giving a period of 2*(`linDiv`+1) clocks and a 50% duty cycle; `linDiv` = 0 and 255 are legal.
- R2: With `linMode`=0 and `expDiv` = M ≥ 1 the serial clock period is 2^M module clocks, one level change every 2^(M-1) clocks.
- R3: `linMode`=1 selects the linear field and ignores `expDiv`; `linMode`=0 selects the exponent field and ignores `linDiv`.
- R4: `expDiv` = 0 behaves exactly as `expDiv` = 1 (level change every clock).
- R5: A divisor or mode change while running takes effect only from the cycle after a trailing edge; while idle it is taken at once, so the first half period after `runEn` rises uses the current settings.
- R6: While `runEn` is low, `sclk` equals `cpol` from the next clock on and `toggleEn`, `leadTick` and `trailTick` stay low; on the rising edge of `runEn` the first toggle falls H clocks later, with H the half period.
- R7: `toggleEn` is high in the cycle before each level change of `sclk`; in that cycle exactly one of `leadTick` (when `sclk` equals `cpol`) or `trailTick` (when it does not) is high.
- R8: During and after reset, with `runEn` low, `sclk` equals `cpol` and no tick is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; low holds the divider idle |
| linMode | input | 1 | 1 = linear divisor, 0 = exponent divisor |
| linDiv | input | 8 | Linear divisor N, period 2*(N+1) |
| expDiv | input | 4 | Exponent divisor M, period 2^M |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| toggleEn | output | 1 | High in the cycle before an `sclk` level change |
| leadTick | output | 1 | Toggle that leaves the idle level |
| trailTick | output | 1 | Toggle that returns to the idle level |

## Verification
The divisor reload and the trailing toggle can fall in the same cycle. So can the run-enable drop and a pending toggle. The bench changes the divisor fields at random points during a run, including in the exact cycle of a trailing edge. It also lowers `runEn` in the middle of half periods. A cycle-level model built from R1 to R6 then decides which half-period length applies next and when `sclk` must return to `cpol`, and every output is compared against it on every cycle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic loadDiv;
  } divStrobes_t;
endpackage

// File: rtl/sclk_div_datapath.sv
module sclk_div_datapath
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strb,
  input  logic             linMode,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [EXP_W-1:0] expDiv,
  output logic             atTerm
);
  localparam int LIN_HALF_MAX = 2 ** LIN_W;
  localparam int EXP_HALF_MAX = 2 ** ((2 ** EXP_W) - 2);
  localparam int HALF_MAX = (LIN_HALF_MAX > EXP_HALF_MAX) ? LIN_HALF_MAX : EXP_HALF_MAX;
  localparam int CNT_W = $clog2(HALF_MAX) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activeHalf;
  logic [CNT_W-1:0] nextHalf;

  always_comb begin
    if (linMode) begin
      nextHalf = CNT_W'(linDiv) + CNT_W'(1);
    end else if (expDiv == '0) begin
      nextHalf = CNT_W'(1);
    end else begin
      nextHalf = CNT_W'(1) << (expDiv - EXP_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      activeHalf <= CNT_W'(1);
    end else begin
      if (strb.clrCnt)      cnt <= '0;
      else if (strb.incCnt) cnt <= cnt + CNT_W'(1);
      if (strb.loadDiv)     activeHalf <= nextHalf;
    end
  end

  assign atTerm = (cnt == activeHalf - CNT_W'(1));
endmodule

// File: rtl/sclk_div_control.sv
module sclk_div_control
  import sclk_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        cpol,
  input  logic        atTerm,
  output divStrobes_t strb,
  output logic        sclk,
  output logic        toggleEn,
  output logic        leadTick,
  output logic        trailTick
);
  logic activePhase;

  always_comb begin
    toggleEn     = runEn & atTerm;
    leadTick     = toggleEn & ~activePhase;
    trailTick    = toggleEn & activePhase;
    strb.clrCnt  = ~runEn | toggleEn;
    strb.incCnt  = runEn & ~atTerm;
    strb.loadDiv = ~runEn | trailTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          activePhase <= 1'b0;
    else if (!runEn)    activePhase <= 1'b0;
    else if (toggleEn)  activePhase <= ~activePhase;
  end

  assign sclk = cpol ^ activePhase;
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             linMode,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [EXP_W-1:0] expDiv,
  input  logic             cpol,
  output logic             sclk,
  output logic             toggleEn,
  output logic             leadTick,
  output logic             trailTick
);
  divStrobes_t strb;
  logic        atTerm;

  sclk_div_datapath #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .linMode(linMode),
    .linDiv(linDiv), .expDiv(expDiv), .atTerm(atTerm)
  );

  sclk_div_control u_ctl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cpol(cpol), .atTerm(atTerm),
    .strb(strb), .sclk(sclk), .toggleEn(toggleEn),
    .leadTick(leadTick), .trailTick(trailTick)
  );
endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic cpol,
  input logic sclk,
  input logic toggleEn,
  input logic leadTick,
  input logic trailTick
);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && $past(!runEn)) |-> (sclk == cpol));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !(toggleEn || leadTick || trailTick));

  // R7
  tick_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({leadTick, trailTick}));

  // R7
  lead_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadTick |-> (sclk == cpol));

  // R7
  trail_from_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    trailTick |-> (sclk != cpol));

  // R1
  toggle_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toggleEn && runEn) |=> ((sclk != $past(sclk)) || !$stable(cpol)));

  // R5
  no_stray_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runEn) && $past(!toggleEn) && $stable(cpol)) |-> $stable(sclk));
endmodule

bind sclk_divider sclk_divider_chk u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .cpol(cpol), .sclk(sclk),
  .toggleEn(toggleEn), .leadTick(leadTick), .trailTick(trailTick)
);

// File: tb/sclk_divider_bench.sv
`timescale 1ns/1ps
module sclk_divider_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic linMode = 1'b1;
  logic [7:0] linDiv = '0;
  logic [3:0] expDiv = '0;
  logic cpol = 1'b0;
  logic sclk, toggleEn, leadTick, trailTick;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string tag = "R8";

  int mCnt = 0;
  int mHalf = 1;
  bit mPhase = 0;

  always #5 clk = ~clk;

  sclk_divider u_sclk_divider (
    .clk(clk), .rstN(rstN), .runEn(runEn), .linMode(linMode),
    .linDiv(linDiv), .expDiv(expDiv), .cpol(cpol), .sclk(sclk),
    .toggleEn(toggleEn), .leadTick(leadTick), .trailTick(trailTick)
  );

  function automatic int halfOf(bit lm, int n, int m);
    if (lm) return n + 1;
    if (m == 0) return 1;
    return 1 << (m - 1);
  endfunction

  // reference model from R1..R6
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= 0; mPhase <= 0; mHalf <= 1;
    end else if (!runEn) begin
      mCnt <= 0; mPhase <= 0; mHalf <= halfOf(linMode, linDiv, expDiv);
    end else if (mCnt == mHalf - 1) begin
      mCnt <= 0;
      mPhase <= ~mPhase;
      if (mPhase) mHalf <= halfOf(linMode, linDiv, expDiv);
    end else begin
      mCnt <= mCnt + 1;
    end
  end

  task automatic checkBit(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN || tag == "R8") begin
      logic expTog;
      expTog = runEn && rstN && (mCnt == mHalf - 1);
      checkBit("sclk", sclk, cpol ^ mPhase);
      checkBit("toggleEn", toggleEn, expTog);
      checkBit("leadTick", leadTick, expTog && !mPhase);
      checkBit("trailTick", trailTick, expTog && mPhase);
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic runFor(string t, bit lm, int n, int m, bit pol, int cycles);
    tag = t;
    runEn = 0; linMode = lm; linDiv = 8'(n); expDiv = 4'(m); cpol = pol;
    waitCycles(2);
    runEn = 1;
    waitCycles(cycles);
    runEn = 0;
    waitCycles(2);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5c1d);
    // R8 reset state
    #2;
    waitCycles(4);
    rstN = 1;
    tag = "R6";
    waitCycles(3);
    cpol = 1;
    waitCycles(3);
    // R1 linear corners
    runFor("R1", 1, 0, 9, 0, 20);
    runFor("R1", 1, 255, 3, 1, 1100);
    runFor("R1", 1, 4, 0, 0, 60);
    // R2 exponent values
    runFor("R2", 0, 77, 1, 0, 20);
    runFor("R2", 0, 12, 5, 1, 100);
    runFor("R2", 0, 0, 15, 0, 33000);
    // R4 clamp
    runFor("R4", 0, 200, 0, 1, 20);
    // R3 ignored field: linear with wild exp, exponent with wild lin
    runFor("R3", 1, 2, 15, 0, 40);
    runFor("R3", 0, 255, 3, 0, 40);
    // R5 change mid run, including in trailing-edge cycles
    tag = "R5";
    linMode = 1; linDiv = 3; cpol = 0; runEn = 0;
    waitCycles(2);
    runEn = 1;
    waitCycles(5);
    linDiv = 9;
    waitCycles(40);
    linMode = 0; expDiv = 2;
    waitCycles(7);
    linMode = 1; linDiv = 0;
    waitCycles(30);
    // R6 drop run mid half period
    tag = "R6";
    runEn = 0;
    waitCycles(3);
    // random mix
    for (int i = 0; i < 300; i++) begin
      tag = "R7";
      if ($urandom_range(0, 3) == 0) runEn = ~runEn;
      if ($urandom_range(0, 4) == 0) linMode = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 4) == 0) linDiv = 8'($urandom_range(0, 12));
      if ($urandom_range(0, 4) == 0) expDiv = 4'($urandom_range(0, 5));
      if (!runEn && $urandom_range(0, 3) == 0) cpol = ~cpol;
      waitCycles($urandom_range(1, 25));
    end
    runEn = 0;
    waitCycles(3);
    summary();
  end
endmodule